// File: doc/BRIEF.md
# Configuration Access Port Adapter

This block sits between several requesters and a configuration-space access path that accepts only full 32-bit transfers. A requester presents a bus, device and function number, a byte offset into that function's 256-byte space, an access size, a direction and write data. The adapter builds the enabled address word, steers it to an address port, and then moves a whole 32-bit word through a data port. Byte and halfword reads are cut out of that word inside the block; byte and halfword writes become a read-modify-write, so the data port never sees a narrow transfer. Offsets that would run past the end of the space are refused with an error and cause no port traffic.

A second addressing style, chosen per request by `flat_mode`, drops the address port and instead presents a word index into a flat configuration window. Requesters share the adapter through a lock: the lowest-numbered waiting requester gets the grant, which is held through its whole sequence, so a read-modify-write cannot be split by another requester.

The controller walks six named states: `S_IDLE` (wait and lock a requester), `S_ADDR_PRE` (address port write before the first data phase), `S_READ` (full-word data read), `S_ADDR_WB` (address port rewrite before a write-back), `S_WRITE` (full-word data write) and `S_DONE` (one-cycle completion). Transitions: `S_IDLE`→`S_DONE` on a refused request; `S_IDLE`→`S_ADDR_PRE` in port-pair mode; `S_IDLE`→`S_READ` or `S_WRITE` in flat mode (word writes go straight to `S_WRITE`); `S_ADDR_PRE`→`S_WRITE` for a word write, else →`S_READ`; `S_READ`→`S_DONE` for a read, →`S_ADDR_WB` for a sub-word write in port-pair mode, →`S_WRITE` for one in flat mode; `S_ADDR_WB`→`S_WRITE`; `S_WRITE`→`S_DONE`; `S_DONE`→`S_IDLE`. Every port state advances only on `pt_ack`.

Top module: `cfg_port_adapter`

## Requirements
- R1: Every address port write carries the word {1, seven zeros, bus[7:0], device[4:0], function[2:0], offset[7:2], 00}; bit 31 is always set and the two low bits are always clear.
- R2: A read performs exactly one 32-bit data read and returns it shifted right by 8×offset[1:0], zero-extended from 8 bits (size code 0) or 16 bits (size code 1); a word read (size code 2) returns the whole word unshifted whatever offset[1:0] is.
- R3: A byte or halfword write first reads the whole word, replaces only the lane selected by an 0xFF or 0xFFFF mask shifted left by 8×offset[1:0] (bits shifted past bit 31 are dropped), and writes all 32 bits back; the other bytes keep their old values.
- R4: A word write performs no data read and exactly one data write of the request's data.
- R5: A request with size code 2 and offset above 252, size code 1 and offset above 254, or size code 3 is refused: done arrives one cycle after the request is taken, with the error bit set, read data zero and no port transaction.
- R6: In port-pair mode each data port transfer is preceded by its own address port write, so a read or word write issues one address write and a sub-word write issues two.
- R7: In flat mode no address port write occurs; each data phase is one transfer of kind 2 whose index is {bus, device, function, offset[7:2]}.
- R8: Port kinds are 0 for the address port, 1 for the data port and 2 for the flat window; a port request stays high with unchanged kind, direction and data until the cycle in which it is acknowledged.
- R9: When several requesters wait, the lowest index is granted; the grant is one-hot, stays on one requester until its done, and a second requester's transfers start only after the first requester's whole sequence ends.
- R10: Done is a one-cycle pulse to the granted requester only; write requests return zero read data.
- R11: After reset no grant, no done and no port request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flat_mode | input | 1 | 1 selects the flat window, 0 the address/data port pair; sampled when a request is taken |
| rq_valid | input | NUM_REQ | Per-requester request, held until that requester's done |
| rq_write | input | NUM_REQ | Per-requester direction, 1 = write |
| rq_size | input | 2×NUM_REQ | Size code: 0 byte, 1 halfword, 2 word, 3 reserved |
| rq_bus | input | 8×NUM_REQ | Bus number |
| rq_dev | input | 5×NUM_REQ | Device number |
| rq_fn | input | 3×NUM_REQ | Function number |
| rq_off | input | 8×NUM_REQ | Byte offset in the configuration space |
| rq_wdata | input | 32×NUM_REQ | Write data, right-aligned |
| rq_grant | output | NUM_REQ | One-hot lock owner |
| rq_done | output | NUM_REQ | Completion pulse to the owner |
| rsp_err | output | 1 | Refusal flag, valid with done |
| rsp_rdata | output | 32 | Read result, valid with done |
| pt_req | output | 1 | Port transfer request |
| pt_kind | output | 2 | 0 address port, 1 data port, 2 flat window |
| pt_we | output | 1 | 1 = port write |
| pt_widx | output | 22 | Flat window word index (zero otherwise) |
| pt_wdata | output | 32 | Port write data, little-endian |
| pt_ack | input | 1 | Port acknowledge; the transfer completes in a cycle with pt_req and pt_ack high |
| pt_rdata | input | 32 | Port read data, valid with pt_ack on a read |

## Verification
A taken request moves the controller at the next edge, so a refused request shows done exactly one cycle after the bench raised it, and an accepted one shows done in the cycle after the edge that carries the final acknowledge. The bench drives requests and acknowledges on the falling edge, waits for done on falling edges with a bounded count, and checks the refusal latency exactly. Port side effects (stored words, transfer counts, address words) are applied by the bench's port model one falling edge after each acknowledged edge, so memory contents and counts are compared one further cycle after done, when the last write-back has certainly landed.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    parameter int DATA_W = 32;
    parameter int BUS_W  = 8;
    parameter int DEV_W  = 5;
    parameter int FN_W   = 3;
    parameter int OFF_W  = 8;
    parameter int SIZE_W = 2;

    localparam int IDX_W  = BUS_W + DEV_W + FN_W + OFF_W - 2;
    localparam int PAD_W  = DATA_W - 1 - IDX_W - 2;
    localparam int LANES  = DATA_W / 8;
    localparam int LOFF_W = $clog2(LANES);
    localparam int SH_W   = LOFF_W + 3;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        PK_ADDR = 2'd0,
        PK_DATA = 2'd1,
        PK_FLAT = 2'd2,
        PK_NONE = 2'd3
    } pkind_e;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_ADDR_PRE = 3'd1,
        S_READ     = 3'd2,
        S_ADDR_WB  = 3'd3,
        S_WRITE    = 3'd4,
        S_DONE     = 3'd5
    } state_e;

    typedef struct packed {
        logic              write;
        size_e             size;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FN_W-1:0]   fn;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] wdata;
    } cmd_t;

endpackage

// File: rtl/cfgp_arbiter.sv
module cfgp_arbiter #(
    parameter int NUM_REQ = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req,
    input  logic               take,
    input  logic               release_lock,
    output logic [NUM_REQ-1:0] pick,
    output logic               any_req,
    output logic [NUM_REQ-1:0] grant
);

    genvar g;
    generate
        for (g = 0; g < NUM_REQ; g++) begin : g_pick
            if (g == 0) begin : g_first
                assign pick[g] = req[g];
            end else begin : g_rest
                assign pick[g] = req[g] & ~(|req[g-1:0]);
            end
        end
    endgenerate

    assign any_req = |req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant <= '0;
        end else if (release_lock) begin
            grant <= '0;
        end else if (take) begin
            grant <= pick;
        end
    end

    // R9
    pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req[0]) |=> grant[0]);

endmodule

// File: rtl/cfgp_addr.sv
module cfgp_addr
    import cfgp_pkg::*;
(
    input  cmd_t              cmd,
    output logic [DATA_W-1:0] addr_word,
    output logic [IDX_W-1:0]  widx,
    output logic              range_err
);

    localparam logic [OFF_W-1:0] OFF_TOP  = {OFF_W{1'b1}};
    localparam logic [OFF_W-1:0] WORD_LIM = OFF_TOP - OFF_W'(3);
    localparam logic [OFF_W-1:0] HALF_LIM = OFF_TOP - OFF_W'(1);

    always_comb begin
        widx      = {cmd.bus, cmd.dev, cmd.fn, cmd.off[OFF_W-1:2]};
        addr_word = {1'b1, {PAD_W{1'b0}}, widx, 2'b00};
        unique case (cmd.size)
            SZ_BYTE: range_err = 1'b0;
            SZ_HALF: range_err = (cmd.off > HALF_LIM);
            SZ_WORD: range_err = (cmd.off > WORD_LIM);
            default: range_err = 1'b1;
        endcase
    end

endmodule

// File: rtl/cfgp_lane.sv
module cfgp_lane
    import cfgp_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [LOFF_W-1:0] lane_off,
    input  size_e             size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0] merged
);

    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] rd_shift;
    logic [DATA_W-1:0] ins;

    always_comb begin
        sh       = (size == SZ_WORD) ? '0 : {lane_off, 3'b000};
        rd_shift = word >> sh;
        ins      = wdata << sh;
        unique case (size)
            SZ_BYTE: rd_val = {{(DATA_W-8){1'b0}}, rd_shift[7:0]};
            SZ_HALF: rd_val = {{(DATA_W-16){1'b0}}, rd_shift[15:0]};
            default: rd_val = rd_shift;
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic hit;
            always_comb begin
                hit = (size == SZ_WORD)
                    || ({1'b0, lane_off} == (LOFF_W+1)'(g))
                    || (size == SZ_HALF && ({1'b0, lane_off} + 1'b1) == (LOFF_W+1)'(g));
            end
            assign merged[g*8 +: 8] = hit ? ins[g*8 +: 8] : word[g*8 +: 8];
        end
    endgenerate

endmodule

// File: rtl/cfg_port_adapter.sv
module cfg_port_adapter
    import cfgp_pkg::*;
#(
    parameter int NUM_REQ = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flat_mode,
    input  logic [NUM_REQ-1:0]          rq_valid,
    input  logic [NUM_REQ-1:0]          rq_write,
    input  logic [NUM_REQ*SIZE_W-1:0]   rq_size,
    input  logic [NUM_REQ*BUS_W-1:0]    rq_bus,
    input  logic [NUM_REQ*DEV_W-1:0]    rq_dev,
    input  logic [NUM_REQ*FN_W-1:0]     rq_fn,
    input  logic [NUM_REQ*OFF_W-1:0]    rq_off,
    input  logic [NUM_REQ*DATA_W-1:0]   rq_wdata,
    output logic [NUM_REQ-1:0]          rq_grant,
    output logic [NUM_REQ-1:0]          rq_done,
    output logic                        rsp_err,
    output logic [DATA_W-1:0]           rsp_rdata,
    output logic                        pt_req,
    output logic [1:0]                  pt_kind,
    output logic                        pt_we,
    output logic [IDX_W-1:0]            pt_widx,
    output logic [DATA_W-1:0]           pt_wdata,
    input  logic                        pt_ack,
    input  logic [DATA_W-1:0]           pt_rdata
);

    state_e state, state_nx;

    cmd_t              cmd_pick, cmd_q, cmd_cur;
    logic              flat_q, err_q;
    logic [DATA_W-1:0] word_q;
    logic [NUM_REQ-1:0] pick;
    logic              any_req, take, release_lock;
    logic [DATA_W-1:0] addr_word, rd_val, merged;
    logic [IDX_W-1:0]  widx;
    logic              range_err;

    // requester field selection
    always_comb begin
        cmd_pick = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (pick[i]) begin
                cmd_pick.write = rq_write[i];
                cmd_pick.size  = size_e'(rq_size[i*SIZE_W +: SIZE_W]);
                cmd_pick.bus   = rq_bus[i*BUS_W +: BUS_W];
                cmd_pick.dev   = rq_dev[i*DEV_W +: DEV_W];
                cmd_pick.fn    = rq_fn[i*FN_W +: FN_W];
                cmd_pick.off   = rq_off[i*OFF_W +: OFF_W];
                cmd_pick.wdata = rq_wdata[i*DATA_W +: DATA_W];
            end
        end
    end

    assign cmd_cur      = (state == S_IDLE) ? cmd_pick : cmd_q;
    assign take         = (state == S_IDLE) && any_req;
    assign release_lock = (state == S_DONE);

    cfgp_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (rq_valid),
        .take         (take),
        .release_lock (release_lock),
        .pick         (pick),
        .any_req      (any_req),
        .grant        (rq_grant)
    );

    cfgp_addr u_addr (
        .cmd       (cmd_cur),
        .addr_word (addr_word),
        .widx      (widx),
        .range_err (range_err)
    );

    cfgp_lane u_lane (
        .word     (word_q),
        .lane_off (cmd_q.off[LOFF_W-1:0]),
        .size     (cmd_q.size),
        .wdata    (cmd_q.wdata),
        .rd_val   (rd_val),
        .merged   (merged)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (any_req) begin
                    if (range_err)
                        state_nx = S_DONE;
                    else if (!flat_mode)
                        state_nx = S_ADDR_PRE;
                    else if (cmd_pick.write && cmd_pick.size == SZ_WORD)
                        state_nx = S_WRITE;
                    else
                        state_nx = S_READ;
                end
            end
            S_ADDR_PRE: begin
                if (pt_ack)
                    state_nx = (cmd_q.write && cmd_q.size == SZ_WORD) ? S_WRITE : S_READ;
            end
            S_READ: begin
                if (pt_ack) begin
                    if (!cmd_q.write)
                        state_nx = S_DONE;
                    else
                        state_nx = flat_q ? S_WRITE : S_ADDR_WB;
                end
            end
            S_ADDR_WB: if (pt_ack) state_nx = S_WRITE;
            S_WRITE:   if (pt_ack) state_nx = S_DONE;
            S_DONE:    state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // request and data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            flat_q <= 1'b0;
            err_q  <= 1'b0;
            word_q <= '0;
        end else if (take) begin
            cmd_q  <= cmd_pick;
            flat_q <= flat_mode;
            err_q  <= range_err;
            word_q <= '0;
        end else if (state == S_READ && pt_ack) begin
            word_q <= pt_rdata;
        end
    end

    // outputs
    always_comb begin
        pt_req    = 1'b0;
        pt_kind   = PK_NONE;
        pt_we     = 1'b0;
        pt_widx   = '0;
        pt_wdata  = '0;
        rq_done   = '0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state)
            S_ADDR_PRE, S_ADDR_WB: begin
                pt_req   = 1'b1;
                pt_kind  = PK_ADDR;
                pt_we    = 1'b1;
                pt_wdata = addr_word;
            end
            S_READ: begin
                pt_req  = 1'b1;
                pt_kind = flat_q ? PK_FLAT : PK_DATA;
                pt_widx = flat_q ? widx : '0;
            end
            S_WRITE: begin
                pt_req   = 1'b1;
                pt_kind  = flat_q ? PK_FLAT : PK_DATA;
                pt_we    = 1'b1;
                pt_widx  = flat_q ? widx : '0;
                pt_wdata = (cmd_q.size == SZ_WORD) ? cmd_q.wdata : merged;
            end
            S_DONE: begin
                rq_done   = rq_grant;
                rsp_err   = err_q;
                rsp_rdata = (err_q || cmd_q.write) ? '0 : rd_val;
            end
            default: ;
        endcase
    end

    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rq_grant));

    // R9
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rq_grant && !(|rq_done)) |=> (rq_grant == $past(rq_grant)));

    // R8
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_req && !pt_ack) |=> (pt_req && $stable(pt_kind) && $stable(pt_we) && $stable(pt_wdata)));

    // R1
    addr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_req && pt_kind == PK_ADDR) |-> (pt_we && pt_wdata[DATA_W-1] && pt_wdata[1:0] == 2'b00));

    // R5
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rq_done && rsp_err) |-> ($past(state) == S_IDLE));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rq_done) |=> !(|rq_done));

    // R10
    done_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rq_done) |-> ((rq_done & ~rq_grant) == '0));

endmodule

// File: tb/sim_cfg_port_adapter.sv
`timescale 1ns/1ps
module sim_cfg_port_adapter;

    localparam int N = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic            flat_mode = 1'b0;
    logic [N-1:0]    rq_valid = '0;
    logic [N-1:0]    rq_write = '0;
    logic [N*2-1:0]  rq_size = '0;
    logic [N*8-1:0]  rq_bus = '0;
    logic [N*5-1:0]  rq_dev = '0;
    logic [N*3-1:0]  rq_fn = '0;
    logic [N*8-1:0]  rq_off = '0;
    logic [N*32-1:0] rq_wdata = '0;
    logic [N-1:0]    rq_grant, rq_done;
    logic            rsp_err;
    logic [31:0]     rsp_rdata;
    logic            pt_req, pt_we;
    logic [1:0]      pt_kind;
    logic [21:0]     pt_widx;
    logic [31:0]     pt_wdata;
    logic            pt_ack = 1'b0;
    logic [31:0]     pt_rdata = '0;

    cfg_port_adapter #(.NUM_REQ(N)) u0 (
        .clk(clk), .rst_n(rst_n), .flat_mode(flat_mode),
        .rq_valid(rq_valid), .rq_write(rq_write), .rq_size(rq_size),
        .rq_bus(rq_bus), .rq_dev(rq_dev), .rq_fn(rq_fn), .rq_off(rq_off),
        .rq_wdata(rq_wdata), .rq_grant(rq_grant), .rq_done(rq_done),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .pt_req(pt_req), .pt_kind(pt_kind), .pt_we(pt_we), .pt_widx(pt_widx),
        .pt_wdata(pt_wdata), .pt_ack(pt_ack), .pt_rdata(pt_rdata)
    );

    int n_checks = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- port model ----------------
    logic [31:0] mem [0:1023];
    logic [31:0] last_addr = '0;
    logic [31:0] exp_addr = '0;
    bit          chk_addr = 1'b1;
    int n_addr = 0, n_rd = 0, n_wr = 0, n_flat = 0, n_bad = 0;

    bit          pend = 0;
    logic [1:0]  pk_kind;
    logic        pk_we;
    logic [31:0] pk_wdata;
    logic [21:0] pk_widx;

    function automatic int ix_of_idx(input logic [21:0] wi);
        // wi = {bus[7:0], dev[4:0], fn[2:0], off[7:2]}
        return {wi[14], wi[10:9], wi[6], wi[5:0]};
    endfunction

    always @(negedge clk) begin
        if (pend) begin
            case (pk_kind)
                2'd0: begin
                    n_addr++;
                    last_addr = pk_wdata;
                    if (!pk_we || !pk_wdata[31]) n_bad++;
                    if (chk_addr && pk_wdata != exp_addr) n_bad++;
                end
                2'd1: begin
                    if (pk_we) begin n_wr++; mem[ix_of_idx(last_addr[23:2])] = pk_wdata; end
                    else n_rd++;
                    if (chk_addr && last_addr != exp_addr) n_bad++;
                end
                2'd2: begin
                    n_flat++;
                    if (pk_we) begin n_wr++; mem[ix_of_idx(pk_widx)] = pk_wdata; end
                    else n_rd++;
                    if (chk_addr && pk_widx != exp_addr[23:2]) n_bad++;
                end
                default: n_bad++;
            endcase
        end
        pend = 0;
        pt_ack = 1'b0;
        if (pt_req && rst_n && ($urandom % 3 != 0)) begin
            pend = 1;
            pk_kind = pt_kind; pk_we = pt_we; pk_wdata = pt_wdata; pk_widx = pt_widx;
            pt_ack = 1'b1;
            if (pt_kind == 2'd2) pt_rdata = mem[ix_of_idx(pt_widx)];
            else pt_rdata = mem[ix_of_idx(last_addr[23:2])];
        end
    end

    // ---------------- reference functions ----------------
    function automatic logic [31:0] ref_read(input logic [31:0] w, input int off, input int sz);
        logic [31:0] t;
        t = w >> ((off & 3) * 8);
        case (sz)
            0: return t & 32'hFF;
            1: return t & 32'hFFFF;
            default: return w;
        endcase
    endfunction

    function automatic logic [31:0] ref_merge(input logic [31:0] w, input int off, input int sz, input logic [31:0] d);
        logic [31:0] m, v;
        if (sz == 2) return d;
        m = (sz == 0) ? 32'hFF : 32'hFFFF;
        v = (d & m) << ((off & 3) * 8);
        m = m << ((off & 3) * 8);
        return (w & ~m) | v;
    endfunction

    function automatic bit ref_err(input int off, input int sz);
        return (sz == 3) || (sz == 2 && off > 252) || (sz == 1 && off > 254);
    endfunction

    // ---------------- one request ----------------
    task automatic do_op(input int r, input bit wr, input int sz, input int bus, input int dev,
                         input int fn, input int off, input logic [31:0] wd, input bit flat);
        int ix, cyc;
        bit er;
        logic [31:0] old, exp_rd;
        @(negedge clk);
        ix  = {bus[0], dev[1:0], fn[0], off[7:2]};
        old = mem[ix];
        er  = ref_err(off, sz);
        exp_addr = 32'h8000_0000 | (bus << 16) | (dev << 11) | (fn << 8) | (off & 252);
        chk_addr = 1'b1;
        n_addr = 0; n_rd = 0; n_wr = 0; n_flat = 0; n_bad = 0;
        flat_mode = flat;
        rq_write[r] = wr;
        rq_size[r*2 +: 2] = sz[1:0];
        rq_bus[r*8 +: 8] = bus[7:0];
        rq_dev[r*5 +: 5] = dev[4:0];
        rq_fn[r*3 +: 3] = fn[2:0];
        rq_off[r*8 +: 8] = off[7:0];
        rq_wdata[r*32 +: 32] = wd;
        rq_valid[r] = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!rq_done[r] && cyc < 60);
        check(rq_done[r] == 1'b1, "R10 done arrives", {31'b0, rq_done[r]}, 32'd1);
        check(rsp_err == er, "R5 error flag", {31'b0, rsp_err}, {31'b0, er});
        if (er) begin
            check(cyc == 1, "R5 refusal latency", cyc, 1);
            check(rsp_rdata == 0, "R5 refused read data", rsp_rdata, 0);
        end else if (!wr) begin
            exp_rd = ref_read(old, off, sz);
            check(rsp_rdata == exp_rd, "R2 read lane", rsp_rdata, exp_rd);
        end else begin
            check(rsp_rdata == 0, "R10 write returns zero", rsp_rdata, 0);
        end
        rq_valid[r] = 1'b0;
        @(negedge clk);
        check(rq_done == '0, "R10 done is one pulse", {30'b0, rq_done}, 0);
        check(n_bad == 0, "R1 address word and target", n_bad, 0);
        if (er) begin
            check(n_addr + n_rd + n_wr == 0, "R5 no port traffic", n_addr + n_rd + n_wr, 0);
            check(mem[ix] == old, "R5 storage untouched", mem[ix], old);
        end else begin
            if (flat) begin
                check(n_addr == 0, "R7 no address port in flat mode", n_addr, 0);
                check(n_flat == n_rd + n_wr, "R7 flat kind used", n_flat, n_rd + n_wr);
            end else begin
                check(n_addr == n_rd + n_wr, "R6 address before each data access", n_addr, n_rd + n_wr);
            end
            if (!wr) begin
                check(n_rd == 1 && n_wr == 0, "R2 single full read", {n_rd[15:0], n_wr[15:0]}, 32'h0001_0000);
                check(mem[ix] == old, "R2 read leaves storage", mem[ix], old);
            end else if (sz == 2) begin
                check(n_rd == 0 && n_wr == 1, "R4 word write without read", {n_rd[15:0], n_wr[15:0]}, 32'h0000_0001);
                check(mem[ix] == wd, "R4 word stored", mem[ix], wd);
            end else begin
                check(n_rd == 1 && n_wr == 1, "R3 read-modify-write", {n_rd[15:0], n_wr[15:0]}, 32'h0001_0001);
                check(mem[ix] == ref_merge(old, off, sz, wd), "R3 merged word", mem[ix], ref_merge(old, off, sz, wd));
            end
        end
    endtask

    // ---------------- watchdog ----------------
    int wd_cnt = 0;
    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", wd_cnt);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;

        repeat (3) @(negedge clk);
        // R11
        check(rq_grant == 0, "R11 no grant in reset", {30'b0, rq_grant}, 0);
        check(pt_req == 0, "R11 no port request in reset", {31'b0, pt_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(rq_done == 0 && rq_grant == 0, "R11 idle after reset", {28'b0, rq_grant, rq_done}, 0);

        // directed corners
        do_op(0, 0, 0, 1, 2, 1, 8'h07, 32'h0, 0);         // R2 byte lane 3
        do_op(0, 0, 1, 0, 3, 0, 8'h03, 32'h0, 0);         // R2 halfword at lane 3
        do_op(1, 0, 2, 1, 1, 1, 8'h11, 32'h0, 0);         // R2 word at unaligned offset
        do_op(0, 1, 0, 0, 1, 0, 8'h12, 32'hFFFF_FFA5, 0); // R3 byte write
        do_op(0, 1, 1, 1, 0, 1, 8'h0F, 32'h0000_BEEF, 0); // R3 halfword crossing top
        do_op(1, 1, 2, 0, 2, 1, 8'h40, 32'hCAFE_F00D, 0); // R4
        do_op(0, 0, 2, 0, 0, 0, 253, 32'h0, 0);           // R5 word above 252
        do_op(0, 0, 2, 1, 3, 1, 252, 32'h0, 0);           // R5 word at 252 accepted
        do_op(0, 1, 1, 0, 0, 0, 255, 32'h1, 0);           // R5 halfword above 254
        do_op(0, 0, 1, 0, 1, 1, 254, 32'h0, 1);           // R7 halfword at 254 accepted
        do_op(1, 0, 0, 0, 1, 0, 255, 32'h0, 0);           // byte at 255 accepted
        do_op(0, 0, 3, 0, 1, 0, 8'h04, 32'h0, 0);         // R5 reserved size
        do_op(0, 1, 0, 1, 2, 0, 8'h21, 32'h0000_0077, 1); // R7 flat RMW
        do_op(1, 1, 2, 1, 2, 0, 8'h24, 32'h1357_9BDF, 1); // R7 flat word write

        // R9 arbitration: both wait, lowest index first, RMW not split
        begin
            logic [31:0] old, after0, exp1;
            int cyc;
            @(negedge clk);
            chk_addr = 1'b0;
            flat_mode = 1'b0;
            old = mem[{1'b0, 2'd1, 1'b1, 6'd5}];
            rq_write = 2'b01;
            rq_size = {2'd2, 2'd0};
            rq_bus = '0; rq_dev = {5'd1, 5'd1}; rq_fn = {3'd1, 3'd1};
            rq_off = {8'd20, 8'd22};
            rq_wdata = {32'h0, 32'h0000_00C3};
            rq_valid = 2'b11;
            @(negedge clk);
            check(rq_grant == 2'b01, "R9 lowest index granted", {30'b0, rq_grant}, 32'd1);
            cyc = 0;
            while (rq_done == 0 && cyc < 60) begin @(negedge clk); cyc++; end
            check(rq_done == 2'b01, "R9 first done to requester 0", {30'b0, rq_done}, 32'd1);
            rq_valid[0] = 1'b0;
            cyc = 0;
            do begin @(negedge clk); cyc++; end while (!rq_done[1] && cyc < 60);
            after0 = ref_merge(old, 22, 0, 32'hC3);
            exp1 = after0;
            check(rq_done == 2'b10, "R9 second done to requester 1", {30'b0, rq_done}, 32'd2);
            check(rsp_rdata == exp1, "R9 second sees completed RMW", rsp_rdata, exp1);
            rq_valid = '0;
            @(negedge clk);
        end

        // constrained random
        for (int k = 0; k < 400; k++) begin
            int r, sz, off;
            bit wr, fl;
            r   = $urandom % 2;
            wr  = $urandom % 2;
            sz  = ($urandom % 8 == 0) ? 3 : ($urandom % 3);
            off = ($urandom % 4 == 0) ? (248 + $urandom % 8) : ($urandom % 256);
            fl  = ($urandom % 3 == 0);
            do_op(r, wr, sz, $urandom % 2, $urandom % 4, $urandom % 2, off, $urandom, fl);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule